// File: doc/BRIEF.md
# Indirect Register Access Window

This block lets a host reach a bank of 32 eight-bit control registers through a single 32-bit memory-mapped word instead of a flat address range. The registers stand in for the settings of an analog block. The host writes the word over a simple bus with a write enable, 32-bit write data and 32-bit read data. Separate fields of the word do four jobs:

- choose a bank entry;
- carry the byte to store;
- strobe the store;
- hold the bank in reset while a level bit stays low.

The low byte of the read data always reflects the entry the address field selects. A read therefore needs only an update of the address field.

A store is committed once, on the rising transition of the strobe bit. The expected software sequence is to write the word with the strobe set, then write it again with the strobe cleared. Leaving the strobe high never commits a second time, whatever happens to the other fields in the meantime.

Top module: `indirect_reg_window`

## Requirements
- R1: A synchronous system reset clears the control word, so `host_rdata` reads 0x00000000 and the bank is held in its cleared state.
- R2: Field layout of the control word: bit 28 is the bank enable (1 = running, 0 = held in reset), bit 24 is the store strobe, bits 20:16 are the entry index, and bits 15:8 are the byte to store. These fields read back as last written.
- R3: When bit 24 goes from 0 to 1 while bit 28 is 1, the byte in bits 15:8 is stored in the entry named by bits 20:16. The new value appears in `host_rdata[7:0]` one clock after the control word has taken the new strobe value.
- R4: Holding bit 24 at 1 commits nothing further, even when the index or the byte field changes while the bit stays high.
- R5: While bit 28 is 0, all entries are forced to 0x00, strobe edges are ignored, and `host_rdata[7:0]` reads 0x00. After the enable is set again, every entry reads 0x00.
- R6: `host_rdata[7:0]` follows the current index field and bank contents without any strobe. It shows the newly selected entry as soon as the control word holds the new index.
- R7: Host data in bits 7:0 is ignored, and bits 31:29, 27:25 and 23:21 always read 0.
- R8: All 32 entries hold independent values. A store to one index leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| host_we | input | 1 | Host write enable for the control word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Control word read-back, with the selected entry in bits 7:0 |

## Verification
The hardest case to reach from the ports is a strobe that stays high while the index and byte fields move. A simple sequence always lowers the strobe between stores, so it never exercises this. The bench writes the word with the strobe set and then rewrites it with a new index and byte while keeping bit 24 at 1. It then reads the second index back to confirm that nothing landed there. A related case raises the strobe while the enable is low and then sets the enable with the strobe still high. This shows that no late commit appears from an edge that happened during the held reset.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 5;
  localparam int BYTE_W    = 8;
  localparam int ENA_BIT   = 28;
  localparam int STB_BIT   = 24;
  localparam int IDX_LSB   = 16;
  localparam int WBYTE_LSB = 8;

  typedef struct packed {
    logic              ena;
    logic              stb;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] wbyte;
  } ctrl_t;
endpackage

// File: rtl/iwin_ctrl_reg.sv
module iwin_ctrl_reg
  import iwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output ctrl_t             ctrl
);
  logic unused_bits;
  assign unused_bits = ^{wdata[WORD_W-1:ENA_BIT+1], wdata[ENA_BIT-1:STB_BIT+1],
                         wdata[STB_BIT-1:IDX_LSB+IDX_W], wdata[WBYTE_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (we) begin
      ctrl.ena   <= wdata[ENA_BIT];
      ctrl.stb   <= wdata[STB_BIT];
      ctrl.idx   <= wdata[IDX_LSB +: IDX_W];
      ctrl.wbyte <= wdata[WBYTE_LSB +: BYTE_W];
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (ctrl == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl)); // R2
endmodule

// File: rtl/iwin_strobe_edge.sv
module iwin_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic enable,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign pulse = enable & level & ~level_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R4
endmodule

// File: rtl/iwin_reg_bank.sv
module iwin_reg_bank #(
  parameter int IDX_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || !ena) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wbyte;
    end
  end

  assign rbyte = ena ? mem[idx] : '0;

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && ena) |=> (mem[$past(idx)] == $past(wbyte))); // R3

  for (genvar g = 0; g < DEPTH; g++) begin : g_hold_chk
    AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !ena |=> (mem[g] == '0)); // R5
  end
endmodule

// File: rtl/indirect_reg_window.sv
module indirect_reg_window
  import iwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  ctrl_t             ctrl;
  logic              commit;
  logic [BYTE_W-1:0] rbyte;

  iwin_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (host_we),
    .wdata (host_wdata),
    .ctrl  (ctrl)
  );

  iwin_strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .level  (ctrl.stb),
    .enable (ctrl.ena),
    .pulse  (commit)
  );

  iwin_reg_bank #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .ena   (ctrl.ena),
    .we    (commit),
    .idx   (ctrl.idx),
    .wbyte (ctrl.wbyte),
    .rbyte (rbyte)
  );

  always_comb begin
    host_rdata                           = '0;
    host_rdata[ENA_BIT]                  = ctrl.ena;
    host_rdata[STB_BIT]                  = ctrl.stb;
    host_rdata[IDX_LSB +: IDX_W]         = ctrl.idx;
    host_rdata[WBYTE_LSB +: BYTE_W]      = ctrl.wbyte;
    host_rdata[BYTE_W-1:0]               = rbyte;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rdata[31:29] == 3'b0) && (host_rdata[27:25] == 3'b0)
    && (host_rdata[23:21] == 3'b0)); // R7
  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (rst)
    !host_rdata[ENA_BIT] |-> (host_rdata[BYTE_W-1:0] == '0)); // R5
endmodule

// File: tb/sim_indirect_reg_window.sv
module sim_indirect_reg_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_mem [32];
  logic       m_ena, m_stb;
  logic [4:0] m_idx;
  logic [7:0] m_byte;

  always #4 clk = ~clk;

  indirect_reg_window u0 (
    .clk(clk), .rst(rst), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [31:0] expect_word();
    logic [31:0] w;
    w = '0;
    w[28] = m_ena;
    w[24] = m_stb;
    w[20:16] = m_idx;
    w[15:8] = m_byte;
    w[7:0] = m_ena ? m_mem[m_idx] : 8'h00;
    return w;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    m_ena = 0; m_stb = 0; m_idx = 0; m_byte = 0;
  endtask

  task automatic model_apply(input logic [31:0] w);
    logic prev;
    prev = m_stb;
    m_ena = w[28]; m_stb = w[24]; m_idx = w[20:16]; m_byte = w[15:8];
    if (!m_ena) begin
      for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    end else if (m_stb && !prev) begin
      m_mem[m_idx] = m_byte;
    end
  endtask

  task automatic check(input string req);
    logic [31:0] e;
    e = expect_word();
    n_chk++;
    if (host_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, host_rdata, e);
    end
  endtask

  task automatic hw(input logic [31:0] w);
    @(negedge clk);
    host_we = 1'b1; host_wdata = w;
    @(negedge clk);
    host_we = 1'b0;
    @(negedge clk);
    model_apply(w);
  endtask

  function automatic logic [31:0] mk(input logic ena, input logic stb,
                                     input logic [4:0] idx, input logic [7:0] b);
    logic [31:0] w;
    w = 32'hE0E0_00A5;
    w[28] = ena; w[24] = stb; w[20:16] = idx; w[15:8] = b;
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state");

    hw(mk(0, 1, 5'd3, 8'h77));
    check("R5 store ignored while disabled");
    hw(mk(0, 0, 5'd3, 8'h77));
    hw(mk(1, 0, 5'd3, 8'h00));
    check("R5 entry zero after enable");

    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 8'hFF);
      hw(mk(1, 0, 5'(i), v));
      hw(mk(1, 1, 5'(i), v));
      check("R3 R7 commit on strobe edge");
      hw(mk(1, 0, 5'(i), 8'h00));
    end
    for (int i = 0; i < 32; i++) begin
      hw(mk(1, 0, 5'(31 - i), 8'h5A));
      check("R6 R8 read-back by index");
    end

    hw(mk(1, 1, 5'd3, 8'hC3));
    check("R3 commit index 3");
    hw(mk(1, 1, 5'd4, 8'h3C));
    check("R4 held strobe no commit at index 4");
    hw(mk(1, 1, 5'd3, 8'h11));
    check("R4 held strobe no recommit index 3");
    hw(mk(1, 0, 5'd4, 8'h00));
    check("R8 index 4 unchanged");

    hw(mk(0, 0, 5'd5, 8'h00));
    check("R5 read zero while disabled");
    hw(mk(0, 1, 5'd6, 8'h99));
    hw(mk(1, 1, 5'd6, 8'h99));
    check("R5 no late commit after enable");
    for (int i = 0; i < 32; i++) begin
      hw(mk(1, 0, 5'(i), 8'h00));
      check("R5 all entries cleared");
    end

    hw(mk(1, 1, 5'd9, 8'hEE));
    check("R2 R3 fields and store");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 mid-run reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule